// File: doc/BRIEF.md
# Modulo Alarm Timer

A 16-bit up-counting timer for one-shot alarms, driven through a small word-addressed register port. The counter advances on a prescaled tick. The tick comes from a fixed-frequency enable input or from the core clock, depending on a source-select field. When the counter has reached the programmed modulo value, the next tick reloads it from a programmable start value and raises a sticky overflow flag. The interrupt output is high while that flag and its enable bit are both set.

Software arms an alarm in a fixed order. It stops the source, loads the start value and the modulo, writes the counter register to reload it, then selects a source and enables the interrupt. The modulo is one less than the wanted period in ticks when the start value is zero. The flag clears only through a read that returns it as 1, followed by a control write with that bit 0. A stray write therefore cannot drop a pending alarm. The port has a single-cycle write strobe, a read strobe and a combinational read path. It carries no streaming data, so it has no valid/ready handshake.

Top module: `mod_alarm_timer`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, the start value reads 0, the modulo reads 0x0000FFFF and `irq` is 0.
- R2: Address bits 3:2 select the register: 0 control, 1 counter, 2 modulo, 3 start value. The counter, modulo and start registers are 16 bits wide, their bits 31:16 read as 0 and writes to those bits are dropped.
- R3: A write of any data to the counter register loads the counter with the start value and not with the data. This load wins over a tick in the same cycle.
- R4: On each prescaled tick the counter increments by one. On the tick where the counter equals the modulo it reloads with the start value instead.
- R5: The overflow flag (control bit 6) sets on the same tick as the modulo-to-start reload, and on no other tick.
- R6: Control bits 4:3 select the tick source: 2 is the `fixed_tick` input, 1 is every core clock, 0 and 3 stop the counter so it holds its value.
- R7: Control bits 2:0 hold a prescale exponent p, and the counter advances once per 2^p source ticks. While the source is stopped the divider is cleared, so a restart always begins a full prescaled period.
- R8: `irq` is high exactly while the flag and the interrupt enable (control bit 5) are both 1.
- R9: A control write with bit 6 at 0 clears the flag only if the most recent control access before it was a read that returned the flag as 1. Writing bit 6 as 1 never changes the flag.
- R10: When an overflow and a flag-clearing write fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fixed_tick | input | 1 | One-cycle enable pulses of the fixed-frequency time base |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, marks a read for flag-clear arming |
| reg_addr | input | 4 | Byte address of a word-aligned register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
The overflow event and the flag-clearing control write are the two functions that can land on the same clock edge. The bench sets up this collision as follows. It counts the fixed tick up to the modulo and reads the control word to arm the clear. It then raises the write strobe and a `fixed_tick` pulse together on one edge. The collision is judged at the ports: `irq` must stay high, the counter must read back the start value, and the control word must still show the flag.

// File: rtl/mtim_pkg.sv
package mtim_pkg;
  localparam int MT_PS_W     = 3;
  localparam int MT_SRC_W    = 2;
  localparam int MT_PS_LSB   = 0;
  localparam int MT_SRC_LSB  = MT_PS_LSB + MT_PS_W;
  localparam int MT_IE_BIT   = MT_SRC_LSB + MT_SRC_W;
  localparam int MT_FLAG_BIT = MT_IE_BIT + 1;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_CNT  = 2'd1,
    RSEL_MOD  = 2'd2,
    RSEL_INIT = 2'd3
  } rsel_e;

  typedef enum logic [MT_SRC_W-1:0] {
    SRC_OFF   = 2'd0,
    SRC_CORE  = 2'd1,
    SRC_FIXED = 2'd2,
    SRC_HOLD  = 2'd3
  } src_e;
endpackage

// File: rtl/mtim_prescaler.sv
module mtim_prescaler
  import mtim_pkg::*;
#(
  parameter int PS_W = MT_PS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  src_e            src_sel,
  input  logic            fixed_tick,
  input  logic [PS_W-1:0] ps,
  output logic            cnt_tick
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [DIV_W-1:0] ALL1 = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             running;
  logic             src_tick;

  assign running  = (src_sel == SRC_CORE) || (src_sel == SRC_FIXED);
  assign src_tick = (src_sel == SRC_CORE) || ((src_sel == SRC_FIXED) && fixed_tick);
  // terminal value of the divider for exponent ps: 2^ps - 1
  assign mask     = ~(ALL1 << ps);
  // ">=" so that lowering ps mid-period never strands the divider above mask
  assign cnt_tick = src_tick && (div_q >= mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!running) begin
      div_q <= '0;
    end else if (src_tick) begin
      if (div_q >= mask) div_q <= '0;
      else               div_q <= div_q + 1'b1;
    end
  end

  // R7: with a non-zero exponent, two prescaled ticks are never adjacent
  p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && ps != '0) |=> (!cnt_tick || !$stable(ps)));
endmodule

// File: rtl/mtim_counter.sv
module mtim_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // a software load suppresses the tick of the same cycle, including its wrap
  assign wrap_o = tick_i && !load_i && (cnt_q == mod_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= init_i;
    end else if (tick_i) begin
      if (cnt_q == mod_i) cnt_q <= init_i;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: a wrap lands on the start value seen at that edge
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == $past(init_i)));

  // R3: a software load lands on the start value as well
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(init_i)));
endmodule

// File: rtl/mtim_regs.sv
module mtim_regs
  import mtim_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  mod_o,
  output logic [CNT_W-1:0]  init_o,
  output logic [MT_PS_W-1:0] ps_o,
  output src_e              src_o,
  output logic              irq
);
  rsel_e              rsel;
  logic               ctrl_wr;
  logic               ctrl_rd;
  logic [MT_PS_W-1:0] ps_q;
  src_e               src_q;
  logic               ie_q;
  logic               flag_q;
  logic               armed_q;
  logic [CNT_W-1:0]   mod_q;
  logic [CNT_W-1:0]   init_q;
  logic [DATA_W-1:0]  ctrl_word;
  logic               unused_bits;

  assign rsel     = rsel_e'(reg_addr[3:2]);
  assign ctrl_wr  = reg_wr && (rsel == RSEL_CTRL);
  assign ctrl_rd  = reg_rd && (rsel == RSEL_CTRL);
  assign cnt_load = reg_wr && (rsel == RSEL_CNT);
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-1:MT_FLAG_BIT+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q   <= '0;
      src_q  <= SRC_OFF;
      ie_q   <= 1'b0;
      mod_q  <= '1;
      init_q <= '0;
    end else if (reg_wr) begin
      case (rsel)
        RSEL_CTRL: begin
          ps_q  <= reg_wdata[MT_PS_LSB +: MT_PS_W];
          src_q <= src_e'(reg_wdata[MT_SRC_LSB +: MT_SRC_W]);
          ie_q  <= reg_wdata[MT_IE_BIT];
        end
        RSEL_MOD:  mod_q  <= reg_wdata[CNT_W-1:0];
        RSEL_INIT: init_q <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // clear is armed by a read that saw the flag set, and disarmed by any control write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (ctrl_wr) begin
      armed_q <= 1'b0;
    end else if (ctrl_rd && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  // set has priority over the clearing write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (wrap_i) begin
      flag_q <= 1'b1;
    end else if (ctrl_wr && armed_q && !reg_wdata[MT_FLAG_BIT]) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[MT_PS_LSB +: MT_PS_W]   = ps_q;
    ctrl_word[MT_SRC_LSB +: MT_SRC_W] = src_q;
    ctrl_word[MT_IE_BIT]              = ie_q;
    ctrl_word[MT_FLAG_BIT]            = flag_q;
  end

  always_comb begin
    case (rsel)
      RSEL_CTRL: reg_rdata = ctrl_word;
      RSEL_CNT:  reg_rdata = DATA_W'(cnt_i);
      RSEL_MOD:  reg_rdata = DATA_W'(mod_q);
      default:   reg_rdata = DATA_W'(init_q);
    endcase
  end

  assign mod_o  = mod_q;
  assign init_o = init_q;
  assign ps_o   = ps_q;
  assign src_o  = src_q;
  assign irq    = flag_q & ie_q;

  // R10: an overflow always leaves the flag set, whatever write shares its cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_q);

  // R9: the flag only falls after an arming read
  p_clear_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q));
endmodule

// File: rtl/mod_alarm_timer.sv
module mod_alarm_timer
  import mtim_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   mod_val;
  logic [CNT_W-1:0]   init_val;
  logic [MT_PS_W-1:0] ps;
  src_e               src_sel;
  logic               cnt_tick;
  logic               cnt_load;
  logic               wrap;

  mtim_regs #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cnt_i    (cnt),
    .wrap_i   (wrap),
    .cnt_load (cnt_load),
    .mod_o    (mod_val),
    .init_o   (init_val),
    .ps_o     (ps),
    .src_o    (src_sel),
    .irq      (irq)
  );

  mtim_prescaler #(
    .PS_W(MT_PS_W)
  ) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .fixed_tick(fixed_tick),
    .ps        (ps),
    .cnt_tick  (cnt_tick)
  );

  mtim_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(cnt_tick),
    .load_i(cnt_load),
    .init_i(init_val),
    .mod_i (mod_val),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  // R6: a stopped source leaves the counter untouched unless software reloads it
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel == SRC_OFF || src_sel == SRC_HOLD) && !cnt_load) |=> $stable(cnt));
endmodule

// File: tb/tb_mod_alarm_timer.sv
`timescale 1ns/100ps
module tb_mod_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_MOD = 4'h8, A_INIT = 4'hC;

  always #2.5 clk = ~clk;

  mod_alarm_timer dut (
    .clk(clk), .rst_n(rst_n), .fixed_tick(fixed_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: compare each read against the next scoreboard entry
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %h expected none", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // all tasks start and end 1 ns after a rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic tk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; fixed_tick = tk;
    @(posedge clk); #1;
    reg_wr = 1'b0; fixed_tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      fixed_tick = 1'b1;
      @(posedge clk); #1;
      fixed_tick = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: actual irq %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_CNT,  32'h0, "R1 cnt");
    rd(A_MOD,  32'h0000FFFF, "R1 mod");
    rd(A_INIT, 32'h0, "R1 init");
    chk_irq(1'b0, "R1 irq");
    // R2 upper bits dropped; R3 counter write loads start value
    wr(A_INIT, 32'hFFFF0005, 1'b0);
    wr(A_MOD,  32'hABCD0007, 1'b0);
    rd(A_MOD,  32'h00000007, "R2 mod upper");
    rd(A_INIT, 32'h00000005, "R2 init upper");
    wr(A_CNT,  32'h00001234, 1'b0);
    rd(A_CNT,  32'h00000005, "R3 load start");
    // R4/R5 fixed tick, no prescale, interrupt disabled
    wr(A_CTRL, 32'h10, 1'b0);
    pulse(2);
    rd(A_CNT,  32'h7, "R4 count to mod");
    rd(A_CTRL, 32'h10, "R5 no flag at mod");
    pulse(1);
    rd(A_CNT,  32'h5, "R4 reload");
    rd(A_CTRL, 32'h50, "R5 flag set");
    chk_irq(1'b0, "R8 masked");
    // R9 writing 1 has no effect; R8 enable
    wr(A_CTRL, 32'h70, 1'b0);
    chk_irq(1'b1, "R8 irq on");
    // R9 write 0 without arming read: no effect
    wr(A_CTRL, 32'h30, 1'b0);
    chk_irq(1'b1, "R9 unarmed write");
    rd(A_CTRL, 32'h70, "R9 flag kept");
    wr(A_CTRL, 32'h30, 1'b0);
    chk_irq(1'b0, "R9 armed clear");
    rd(A_CTRL, 32'h30, "R9 flag cleared");
    // R6 stopped sources hold
    wr(A_CTRL, 32'h20, 1'b0);
    pulse(3);
    rd(A_CNT, 32'h5, "R6 src 0 holds");
    wr(A_CTRL, 32'h38, 1'b0);
    pulse(2);
    rd(A_CNT, 32'h5, "R6 src 3 holds");
    // R7 prescale exponent 2
    wr(A_CNT,  32'h0, 1'b0);
    wr(A_CTRL, 32'h12, 1'b0);
    pulse(3);
    rd(A_CNT, 32'h5, "R7 three source ticks");
    pulse(1);
    rd(A_CNT, 32'h6, "R7 fourth source tick");
    pulse(4);
    rd(A_CNT, 32'h7, "R7 next period");
    pulse(2);
    wr(A_CTRL, 32'h02, 1'b0);
    wr(A_CTRL, 32'h12, 1'b0);
    pulse(3);
    rd(A_CNT, 32'h7, "R7 divider cleared on stop");
    pulse(1);
    rd(A_CNT, 32'h5, "R7 wrap after restart");
    rd(A_CTRL, 32'h52, "R5 flag prescaled");
    wr(A_CTRL, 32'h00, 1'b0);
    rd(A_CTRL, 32'h00, "R9 clear");
    // R6 core clock source
    wr(A_INIT, 32'h0, 1'b0);
    wr(A_MOD,  32'hFFFF, 1'b0);
    wr(A_CNT,  32'h0, 1'b0);
    wr(A_CTRL, 32'h08, 1'b0);
    repeat (9) @(posedge clk);
    #1;
    wr(A_CTRL, 32'h00, 1'b0);
    rd(A_CNT, 32'd10, "R6 core clock");
    // R10 overflow coincides with armed clearing write
    wr(A_MOD,  32'h3, 1'b0);
    wr(A_CNT,  32'h0, 1'b0);
    wr(A_CTRL, 32'h30, 1'b0);
    pulse(4);
    chk_irq(1'b1, "R5 wrap irq");
    pulse(3);
    rd(A_CNT,  32'h3, "R4 at mod");
    rd(A_CTRL, 32'h70, "R10 arm");
    wr(A_CTRL, 32'h30, 1'b1);
    chk_irq(1'b1, "R10 set wins");
    rd(A_CNT,  32'h0, "R10 reload");
    rd(A_CTRL, 32'h70, "R10 flag kept");
    // R3 load wins over tick
    pulse(2);
    wr(A_CNT, 32'hFFFF, 1'b1);
    rd(A_CNT, 32'h0, "R3 load over tick");
    #10;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule